// File: doc/BRIEF.md
# Linked-List Receive DMA Engine

This block takes data offered by a receiving client and stores it into memory buffers. Each buffer is described by a four-word data descriptor in memory, and the descriptors form a linked list. The engine is started with the byte address of the first descriptor. It reads the four words, takes the buffer start as its fill pointer, and then accepts client bytes one word-lane group at a time. Each write uses byte enables, so that no byte outside the accepted range changes.

A descriptor is closed in two cases: when the fill pointer reaches the descriptor's end address, or when the client marks end of packet and every byte it offered has been taken. On close, the engine writes the flags word back with the received-end-of-packet bit added when the close came from end of packet. It then writes the end-address word back as the actual fill address. Closing also raises raw interrupt bits. The engine then either follows the next link or, if the descriptor is the last in the list, stops and raises a list-end flag. Bytes it cannot take stay with the client, which offers them again.

Top module: `rxdma_engine`

## Requirements
- R1: After reset, eol_o and intr_raw_o are 0, irq_upd_o and ctx_dis_o are low, no memory request is made, and the engine is stopped: any offer is taken with an accepted length of 0.
- R2: A descriptor is four DW-wide words at a byte address. Word offset 0 holds the next-descriptor address. Offset BYTES holds the buffer start. Offset 2·BYTES holds the flags: bit 0 marks the last descriptor, bit 1 requests an interrupt, bit 2 records received end of packet. Offset 3·BYTES holds the exclusive end address. After loading a descriptor, the first byte taken lands at the buffer start.
- R3: When an offer is taken while running, acc_len_o equals the minimum of three values: (end address − fill pointer), in_len_i, and (BYTES − fill pointer mod BYTES). The fill pointer then advances by that amount.
- R4: Accepted bytes are written in one word write to the word that holds the fill pointer. Input lane i goes to byte address pointer+i. mem_be_o has exactly the accepted bytes set, so bytes outside the buffer are never modified.
- R5: A descriptor closes when the fill pointer reaches the end address (this includes a zero-length buffer, which takes 0 bytes). It also closes when in_eop_i is offered and the whole offered length is taken. An end-of-packet offer with bytes left over does not close.
- R6: On close, the engine writes the flags word back with bit 2 set if the close was caused by end of packet (other bits unchanged). It then writes the end-address word back as the final fill pointer. If the descriptor is not the last, it then loads the descriptor at the next link.
- R7: A close of a descriptor with flag bit 1 sets raw bits 1:0. A close caused by end of packet sets raw bit 3. irq_upd_o pulses for one cycle only when these bits change intr_raw_o. Ones on intr_ack_i clear the matching raw bits.
- R8: After writing back a descriptor that has flag bit 0 set, eol_o is set, ctx_dis_o pulses once, and the engine stops.
- R9: While eol_o is set, every offer is taken with acc_len_o 0 and no memory write.
- R10: A kick_i pulse while stopped clears eol_o and restarts the engine at desc_ptr_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| kick_i | input | 1 | Start pulse, honoured while stopped |
| desc_ptr_i | input | AW | Byte address of first descriptor |
| in_valid_i | input | 1 | Client offers data |
| in_data_i | input | DW | Offered bytes, first byte in lane 0 |
| in_len_i | input | OFFW+1 | Number of offered bytes, 1..BYTES |
| in_eop_i | input | 1 | Offer ends a packet |
| in_ready_o | output | 1 | Offer is taken this cycle |
| acc_len_o | output | OFFW+1 | Bytes accepted from the offer taken this cycle |
| mem_req_o | output | 1 | Memory access |
| mem_we_o | output | 1 | Access is a write |
| mem_addr_o | output | AW | Byte address, word aligned |
| mem_wdata_o | output | DW | Write data |
| mem_be_o | output | BYTES | Byte enables |
| mem_rdata_i | input | DW | Read data, one cycle after the read request |
| intr_ack_i | input | 4 | Clear raw interrupt bits |
| intr_raw_o | output | 4 | Raw interrupt bits |
| irq_upd_o | output | 1 | One-cycle pulse when a close changed the raw bits |
| eol_o | output | 1 | End of list reached |
| ctx_dis_o | output | 1 | One-cycle pulse marking the context disabled |

## Verification
The bench builds the engine with AW=10 and DW=32, so that a 1 KiB byte array serves as the memory. With four byte lanes, the list it runs contains an unaligned buffer start, a lane limit that splits an offer, a buffer that fills in mid-word, a zero-length buffer, and an end-of-packet offer with leftover bytes. The chain also has a close that leaves the raw interrupts unchanged, a stop at list end, and a restart. All of these fall within five descriptors.

// File: rtl/rxdma_pkg.sv
package rxdma_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FREQ,
    ST_FCAP,
    ST_RUN,
    ST_WB_FLAGS,
    ST_WB_AFTER
  } rx_state_e;

  // descriptor word indices (behavioural: the layout is shared with software)
  localparam int W_NEXT  = 0;
  localparam int W_BUF   = 1;
  localparam int W_FLAGS = 2;
  localparam int W_AFTER = 3;

  // flag bit positions
  localparam int FLAG_LAST  = 0;
  localparam int FLAG_INTR  = 1;
  localparam int FLAG_INEOP = 2;

  // raw interrupt bits
  localparam int IRQ_W = 4;

  function automatic int unsigned min3(int unsigned a, int unsigned b, int unsigned c);
    int unsigned m;
    m = (a < b) ? a : b;
    return (m < c) ? m : c;
  endfunction

  // bytes left in the current word when the pointer has the given lane offset
  function automatic int unsigned lane_room(int unsigned bytes, int unsigned off);
    return bytes - off;
  endfunction

endpackage

// File: rtl/rxdma_accept.sv
module rxdma_accept
  import rxdma_pkg::*;
#(
  parameter int AW    = 16,
  parameter int BYTES = 4,
  parameter int OFFW  = 2,
  parameter int LW    = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          active_i,
  input  logic          take_i,
  input  logic [AW-1:0] ptr_i,
  input  logic [AW-1:0] after_i,
  input  logic [LW-1:0] len_i,
  input  logic          eop_i,
  output logic [LW-1:0] acc_o,
  output logic          full_o,
  output logic          eop_hit_o
);

  logic [AW-1:0] room;
  int unsigned   amount;

  always_comb begin
    room   = after_i - ptr_i;
    amount = active_i ? min3(32'(room), 32'(len_i),
                             lane_room(BYTES, 32'(ptr_i[OFFW-1:0]))) : 0;
    acc_o     = amount[LW-1:0];
    full_o    = active_i && (amount == 32'(room));
    eop_hit_o = active_i && eop_i && (amount == 32'(len_i));
  end

  p_acc_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    take_i |-> (acc_o <= len_i));

endmodule

// File: rtl/rxdma_lane_pack.sv
module rxdma_lane_pack #(
  parameter int DW    = 32,
  parameter int BYTES = 4,
  parameter int OFFW  = 2,
  parameter int LW    = 3
) (
  input  logic [OFFW-1:0] off_i,
  input  logic [LW-1:0]   cnt_i,
  input  logic [DW-1:0]   data_i,
  output logic [DW-1:0]   wdata_o,
  output logic [BYTES-1:0] be_o
);

  assign wdata_o = data_i << (8 * off_i);

  for (genvar j = 0; j < BYTES; j++) begin : g_lane
    assign be_o[j] = (j >= int'(off_i)) && (j < int'(off_i) + int'(cnt_i));
  end

endmodule

// File: rtl/rxdma_irq_acc.sv
module rxdma_irq_acc
  import rxdma_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IRQ_W-1:0] set_i,
  input  logic [IRQ_W-1:0] ack_i,
  output logic [IRQ_W-1:0] raw_o,
  output logic             upd_o
);

  logic [IRQ_W-1:0] raw_next;
  logic             changed;

  assign raw_next = (raw_o & ~ack_i) | set_i;
  assign changed  = |(set_i & ~raw_o);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_o <= '0;
      upd_o <= 1'b0;
    end else begin
      raw_o <= raw_next;
      upd_o <= changed;
    end
  end

  p_upd_means_change_r7: assert property (@(posedge clk) disable iff (!rst_n)
    upd_o |-> (raw_o != $past(raw_o)));

  p_set_lands_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_i) |=> ((raw_o & $past(set_i)) == $past(set_i)));

endmodule

// File: rtl/rxdma_engine.sv
module rxdma_engine
  import rxdma_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  kick_i,
  input  logic [AW-1:0]         desc_ptr_i,
  input  logic                  in_valid_i,
  input  logic [DW-1:0]         in_data_i,
  input  logic [$clog2(DW/8):0] in_len_i,
  input  logic                  in_eop_i,
  output logic                  in_ready_o,
  output logic [$clog2(DW/8):0] acc_len_o,
  output logic                  mem_req_o,
  output logic                  mem_we_o,
  output logic [AW-1:0]         mem_addr_o,
  output logic [DW-1:0]         mem_wdata_o,
  output logic [DW/8-1:0]       mem_be_o,
  input  logic [DW-1:0]         mem_rdata_i,
  input  logic [3:0]            intr_ack_i,
  output logic [3:0]            intr_raw_o,
  output logic                  irq_upd_o,
  output logic                  eol_o,
  output logic                  ctx_dis_o
);

  localparam int BYTES = DW / 8;
  localparam int OFFW  = $clog2(BYTES);
  localparam int LW    = OFFW + 1;

  rx_state_e     state;
  logic [1:0]    fidx;
  logic [AW-1:0] dsc, nxt, ptr, after;
  logic [DW-1:0] flags;
  logic          close_eop_q;
  logic          eol_q, ctx_dis_q;

  // named internal events
  logic          running, take, data_wr, close_now, full, eop_hit;
  logic [LW-1:0] acc;
  logic [DW-1:0] pack_data;
  logic [BYTES-1:0] pack_be;
  logic [DW-1:0] wb_flags;
  logic [IRQ_W-1:0] irq_set;

  assign running    = (state == ST_RUN);
  assign in_ready_o = running || (state == ST_IDLE);
  assign take       = in_valid_i && in_ready_o;
  assign acc_len_o  = acc;
  assign data_wr    = take && running && (acc != '0);
  assign close_now  = take && running && (full || eop_hit);
  assign eol_o      = eol_q;
  assign ctx_dis_o  = ctx_dis_q;

  rxdma_accept #(.AW(AW), .BYTES(BYTES), .OFFW(OFFW), .LW(LW)) u_accept (
    .clk      (clk),
    .rst_n    (rst_n),
    .active_i (running),
    .take_i   (take),
    .ptr_i    (ptr),
    .after_i  (after),
    .len_i    (in_len_i),
    .eop_i    (in_eop_i),
    .acc_o    (acc),
    .full_o   (full),
    .eop_hit_o(eop_hit)
  );

  rxdma_lane_pack #(.DW(DW), .BYTES(BYTES), .OFFW(OFFW), .LW(LW)) u_pack (
    .off_i  (ptr[OFFW-1:0]),
    .cnt_i  (acc),
    .data_i (in_data_i),
    .wdata_o(pack_data),
    .be_o   (pack_be)
  );

  always_comb begin
    irq_set = '0;
    if (close_now) begin
      irq_set[0] = flags[FLAG_INTR];
      irq_set[1] = flags[FLAG_INTR];
      irq_set[3] = eop_hit;
    end
  end

  rxdma_irq_acc u_irq (
    .clk  (clk),
    .rst_n(rst_n),
    .set_i(irq_set),
    .ack_i(intr_ack_i),
    .raw_o(intr_raw_o),
    .upd_o(irq_upd_o)
  );

  always_comb begin
    wb_flags = flags;
    wb_flags[FLAG_INEOP] = flags[FLAG_INEOP] | close_eop_q;
  end

  // memory port
  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = '0;
    mem_wdata_o = '0;
    mem_be_o    = '0;
    unique case (state)
      ST_FREQ: begin
        mem_req_o  = 1'b1;
        mem_addr_o = dsc + AW'(BYTES * int'(fidx));
      end
      ST_RUN: begin
        if (data_wr) begin
          mem_req_o   = 1'b1;
          mem_we_o    = 1'b1;
          mem_addr_o  = {ptr[AW-1:OFFW], {OFFW{1'b0}}};
          mem_wdata_o = pack_data;
          mem_be_o    = pack_be;
        end
      end
      ST_WB_FLAGS: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = dsc + AW'(BYTES * W_FLAGS);
        mem_wdata_o = wb_flags;
        mem_be_o    = '1;
      end
      ST_WB_AFTER: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = dsc + AW'(BYTES * W_AFTER);
        mem_wdata_o = DW'(ptr);
        mem_be_o    = '1;
      end
      default: ;
    endcase
  end

  // sequencing
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      fidx        <= '0;
      dsc         <= '0;
      nxt         <= '0;
      ptr         <= '0;
      after       <= '0;
      flags       <= '0;
      close_eop_q <= 1'b0;
      eol_q       <= 1'b0;
      ctx_dis_q   <= 1'b0;
    end else begin
      ctx_dis_q <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (kick_i) begin
            dsc   <= desc_ptr_i;
            fidx  <= '0;
            eol_q <= 1'b0;
            state <= ST_FREQ;
          end
        end
        ST_FREQ: state <= ST_FCAP;
        ST_FCAP: begin
          unique case (int'(fidx))
            W_NEXT:  nxt   <= mem_rdata_i[AW-1:0];
            W_BUF:   ptr   <= mem_rdata_i[AW-1:0];
            W_FLAGS: flags <= mem_rdata_i;
            default: after <= mem_rdata_i[AW-1:0];
          endcase
          if (int'(fidx) == W_AFTER) begin
            state <= ST_RUN;
          end else begin
            fidx  <= fidx + 2'd1;
            state <= ST_FREQ;
          end
        end
        ST_RUN: begin
          if (take) begin
            ptr <= ptr + AW'(acc);
            if (close_now) begin
              close_eop_q <= eop_hit;
              state       <= ST_WB_FLAGS;
            end
          end
        end
        ST_WB_FLAGS: state <= ST_WB_AFTER;
        ST_WB_AFTER: begin
          if (flags[FLAG_LAST]) begin
            eol_q     <= 1'b1;
            ctx_dis_q <= 1'b1;
            state     <= ST_IDLE;
          end else begin
            dsc   <= nxt;
            fidx  <= '0;
            state <= ST_FREQ;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  p_stopped_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> !mem_req_o);

  p_be_matches_acc_r4: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr |-> ($countones(mem_be_o) == int'(acc_len_o)));

  p_close_writes_back_r6: assert property (@(posedge clk) disable iff (!rst_n)
    close_now |=> (mem_req_o && mem_we_o && (mem_be_o == '1)));

  p_ctx_dis_with_eol_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ctx_dis_o |-> eol_o);

  p_eol_takes_nothing_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (eol_o && in_valid_i && in_ready_o) |-> ((acc_len_o == '0) && !mem_req_o));

endmodule

// File: tb/rxdma_engine_tb_top.sv
`timescale 1ns/100ps
module rxdma_engine_tb_top;

  localparam int AW = 10;
  localparam int DW = 32;
  localparam int LW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic          kick_i = 1'b0;
  logic [AW-1:0] desc_ptr_i = '0;
  logic          in_valid_i = 1'b0;
  logic [DW-1:0] in_data_i = '0;
  logic [LW-1:0] in_len_i = '0;
  logic          in_eop_i = 1'b0;
  logic          in_ready_o;
  logic [LW-1:0] acc_len_o;
  logic          mem_req_o, mem_we_o;
  logic [AW-1:0] mem_addr_o;
  logic [DW-1:0] mem_wdata_o;
  logic [3:0]    mem_be_o;
  logic [DW-1:0] mem_rdata_i = '0;
  logic [3:0]    intr_ack_i = '0;
  logic [3:0]    intr_raw_o;
  logic          irq_upd_o, eol_o, ctx_dis_o;

  rxdma_engine #(.AW(AW), .DW(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .kick_i(kick_i), .desc_ptr_i(desc_ptr_i),
    .in_valid_i(in_valid_i), .in_data_i(in_data_i), .in_len_i(in_len_i),
    .in_eop_i(in_eop_i), .in_ready_o(in_ready_o), .acc_len_o(acc_len_o),
    .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .mem_be_o(mem_be_o), .mem_rdata_i(mem_rdata_i),
    .intr_ack_i(intr_ack_i), .intr_raw_o(intr_raw_o), .irq_upd_o(irq_upd_o),
    .eol_o(eol_o), .ctx_dis_o(ctx_dis_o)
  );

  // memory model
  logic [7:0] mem [0:1023];
  always @(posedge clk) begin
    if (mem_req_o) begin
      if (mem_we_o) begin
        for (int b = 0; b < 4; b++)
          if (mem_be_o[b]) mem[int'(mem_addr_o) + b] <= mem_wdata_o[8*b +: 8];
      end else begin
        mem_rdata_i <= {mem[int'(mem_addr_o)+3], mem[int'(mem_addr_o)+2],
                        mem[int'(mem_addr_o)+1], mem[int'(mem_addr_o)]};
      end
    end
  end

  function automatic logic [31:0] rd32(int a);
    return {mem[a+3], mem[a+2], mem[a+1], mem[a]};
  endfunction

  task automatic wr32(int a, logic [31:0] v);
    for (int b = 0; b < 4; b++) mem[a+b] = v[8*b +: 8];
  endtask

  int vectors = 0;
  int fails = 0;
  bit done = 0;

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // scoreboard of expected memory writes
  typedef struct {
    int          a;
    logic [31:0] d;
    logic [3:0]  be;
    string       tag;
  } wr_t;
  wr_t expq[$];
  int  ctx_pulses = 0;

  always begin
    @(negedge clk);
    #1.5;
    if (ctx_dis_o) ctx_pulses++;
    if (mem_req_o && mem_we_o) begin
      if (expq.size() == 0) begin
        chk(1'b0, "R9 unexpected write", 32'(mem_addr_o), 32'hFFFF_FFFF);
      end else begin
        wr_t e;
        logic [31:0] bm;
        e = expq.pop_front();
        for (int b = 0; b < 4; b++) bm[8*b +: 8] = {8{e.be[b]}};
        chk(int'(mem_addr_o) == e.a, {e.tag, " addr"}, 32'(mem_addr_o), 32'(e.a));
        chk(mem_be_o == e.be, {e.tag, " be"}, 32'(mem_be_o), 32'(e.be));
        chk((mem_wdata_o & bm) == (e.d & bm), {e.tag, " data"},
            mem_wdata_o & bm, e.d & bm);
      end
    end
  end

  // reference model
  bit          m_run = 0;
  int          m_dsc, m_next, m_ptr, m_after;
  logic [31:0] m_flags;
  logic [3:0]  m_raw = '0;

  task automatic m_load(int d);
    m_dsc   = d;
    m_next  = int'(rd32(d));
    m_ptr   = int'(rd32(d + 4));
    m_flags = rd32(d + 8);
    m_after = int'(rd32(d + 12));
  endtask

  task automatic offer_once(logic [31:0] data, int len, bit eop, output int acc);
    int exp_acc, room, lane;
    bit full, eoph, closed, exp_upd;
    logic [3:0] set;
    @(negedge clk);
    in_valid_i = 1'b1;
    in_data_i  = data;
    in_len_i   = LW'(len);
    in_eop_i   = eop;
    #1;
    while (!in_ready_o) begin
      @(negedge clk);
      #1;
    end
    closed = 0;
    exp_upd = 0;
    if (m_run) begin
      room = m_after - m_ptr;
      lane = 4 - (m_ptr % 4);
      exp_acc = room;
      if (len < exp_acc) exp_acc = len;
      if (lane < exp_acc) exp_acc = lane;
    end else begin
      exp_acc = 0;
    end
    chk(int'(acc_len_o) == exp_acc, m_run ? "R3 accepted length" : "R9 stopped accepts 0",
        32'(acc_len_o), 32'(exp_acc));
    if (m_run) begin
      if (exp_acc > 0)
        expq.push_back('{m_ptr & ~3, data << (8 * (m_ptr % 4)),
                         4'(((1 << exp_acc) - 1) << (m_ptr % 4)), "R2 R4 data write"});
      m_ptr += exp_acc;
      full = (exp_acc == room);
      eoph = eop && (exp_acc == len);
      if (full || eoph) begin
        closed = 1;
        expq.push_back('{m_dsc + 8, m_flags | (eoph ? 32'h4 : 32'h0), 4'hF, "R6 flags writeback"});
        expq.push_back('{m_dsc + 12, 32'(m_ptr), 4'hF, "R6 end writeback"});
        set = {eoph, 1'b0, {2{m_flags[1]}}};
        exp_upd = |(set & ~m_raw);
        m_raw |= set;
        if (m_flags[0]) m_run = 0;
        else m_load(m_next);
      end
    end
    acc = exp_acc;
    @(posedge clk);
    @(negedge clk);
    in_valid_i = 1'b0;
    in_eop_i   = 1'b0;
    #1;
    if (closed) begin
      chk(intr_raw_o == m_raw, "R7 raw interrupt", 32'(intr_raw_o), 32'(m_raw));
      chk(irq_upd_o == exp_upd, "R7 update pulse", 32'(irq_upd_o), 32'(exp_upd));
    end
  endtask

  task automatic offer_all(logic [31:0] data, int len, bit eop);
    int a;
    while (len > 0) begin
      offer_once(data, len, eop, a);
      if (a == 0 && !m_run) break;
      data = data >> (8 * a);
      len -= a;
    end
  endtask

  task automatic kick(int d);
    @(negedge clk);
    kick_i = 1'b1;
    desc_ptr_i = AW'(d);
    @(posedge clk);
    @(negedge clk);
    kick_i = 1'b0;
    m_run = 1;
    m_load(d);
    #1;
    chk(eol_o == 1'b0, "R10 kick clears eol", 32'(eol_o), 32'h0);
  endtask

  task automatic ack(logic [3:0] v);
    @(negedge clk);
    intr_ack_i = v;
    @(posedge clk);
    @(negedge clk);
    intr_ack_i = '0;
    m_raw &= ~v;
    #1;
    chk(intr_raw_o == m_raw, "R7 ack clears", 32'(intr_raw_o), 32'(m_raw));
  endtask

  task automatic wait_eol(int pulses);
    int n = 0;
    while (!eol_o && n < 20) begin
      @(negedge clk);
      #1;
      n++;
    end
    chk(eol_o == 1'b1, "R8 eol set", 32'(eol_o), 32'h1);
    @(negedge clk);
    #1;
    chk(ctx_pulses == pulses, "R8 context disable pulses", 32'(ctx_pulses), 32'(pulses));
  endtask

  initial begin
    int a;
    for (int i = 0; i < 1024; i++) mem[i] = 8'hEE;
    // chain: D0 fills, D1 unaligned closed by eop, D2 zero length, D3 last
    wr32(12'h100, 32'h110); wr32(12'h104, 32'h200); wr32(12'h108, 32'h2); wr32(12'h10C, 32'h20A);
    wr32(12'h110, 32'h120); wr32(12'h114, 32'h241); wr32(12'h118, 32'h0); wr32(12'h11C, 32'h260);
    wr32(12'h120, 32'h130); wr32(12'h124, 32'h280); wr32(12'h128, 32'h2); wr32(12'h12C, 32'h280);
    wr32(12'h130, 32'h000); wr32(12'h134, 32'h2A2); wr32(12'h138, 32'h3); wr32(12'h13C, 32'h2A5);
    wr32(12'h140, 32'h000); wr32(12'h144, 32'h300); wr32(12'h148, 32'h1); wr32(12'h14C, 32'h308);

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(eol_o == 0, "R1 eol after reset", 32'(eol_o), 0);
    chk(intr_raw_o == 0, "R1 raw after reset", 32'(intr_raw_o), 0);
    chk(mem_req_o == 0, "R1 no request", 32'(mem_req_o), 0);
    chk(irq_upd_o == 0 && ctx_dis_o == 0, "R1 pulses low", 32'({irq_upd_o, ctx_dis_o}), 0);
    offer_once(32'hAABBCCDD, 4, 1'b0, a);   // R1: stopped engine takes 0

    kick(12'h100);
    offer_all(32'h13121110, 4, 1'b0);
    offer_all(32'h17161514, 4, 1'b0);
    offer_all(32'h1B1A1918, 4, 1'b0);       // R5 full close mid-word, leftover to D1
    offer_all(32'h001E1D1C, 3, 1'b1);       // R5 eop with leftover, then eop close
    ack(4'hB);
    offer_all(32'h23222120, 4, 1'b0);       // R5 zero-length D2, then last D3, R9 refusal
    wait_eol(1);
    offer_once(32'h55555555, 4, 1'b1, a);   // R9 second refusal
    chk(a == 0, "R9 no bytes while eol", 32'(a), 0);

    kick(12'h140);
    offer_all(32'h33323130, 4, 1'b1);
    wait_eol(2);

    repeat (4) @(negedge clk);
    chk(expq.size() == 0, "R6 all expected writes seen", 32'(expq.size()), 0);
    chk(mem[12'h20A] == 8'hEE, "R4 byte past buffer untouched", 32'(mem[12'h20A]), 32'hEE);
    chk(mem[12'h240] == 8'hEE, "R4 byte before buffer untouched", 32'(mem[12'h240]), 32'hEE);
    chk(mem[12'h241] == 8'h1A, "R2 first byte at buffer start", 32'(mem[12'h241]), 32'h1A);
    chk(mem[12'h245] == 8'h1E, "R5 last eop byte", 32'(mem[12'h245]), 32'h1E);
    chk(mem[12'h246] == 8'hEE, "R4 byte after eop untouched", 32'(mem[12'h246]), 32'hEE);
    chk(rd32(12'h11C) == 32'h246, "R6 end field is fill address", rd32(12'h11C), 32'h246);
    chk(rd32(12'h118) == 32'h4, "R6 eop flag written", rd32(12'h118), 32'h4);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      vectors++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

endmodule